// File: doc/BRIEF.md
# Kernel Launch Register Interface

This block is the host-facing front end of a compute dispatcher. A host reaches it through a simple request/response register bus covering a fixed 4096-byte window. The first eight bytes of the window form a combined status and launch word. The bytes above it form a staging area where the host builds a launch descriptor: three grid extents followed by three workgroup extents. The host can build the descriptor with accesses of 1, 2, 4 or 8 bytes and can read it back.

Any write to the launch word starts a launch. The block takes the lowest free entry of an eight-entry slot table and tags it with the next kernel identifier. The bus is stalled while three iterative dividers compute the workgroup count of each dimension by ceiling division. The block then fills the slot with the three counts and their product, and appends the slot to a pending queue. A downstream issue stage reads the head of that queue, pops it, and later retires the slot.

Top module: `kernel_launch_regs`

## Requirements
- R1: After reset no response is pending, the pending queue is empty, the bus is ready, and an 8-byte read of offset 0 returns zero.
- R2: An 8-byte read of offset 0 returns the active flag in bit 0 and the launch-error flag in bit 1, with all other bits zero. The read clears the error flag, so it reports the value held before the clear.
- R3: Offset 8 plus k addresses descriptor byte k, little-endian. `reqSize` selects 1, 2, 4 or 8 bytes (codes 0 to 3). Grid extents x, y and z sit at descriptor bytes 0, 4 and 8. Workgroup extents x, y and z sit at bytes 12, 16 and 20, each 32 bits wide. Reads return the staged bytes zero-extended, and writes update only the addressed bytes.
- R4: Each of the following gets a response with `rspErr` set, read data zero and no change of state:
  - an address of 4096 or above;
  - an address that is not a multiple of the access size;
  - an access at offsets 1 to 7;
  - a read of offset 0 that is not 8 bytes;
  - an access that reaches past the 24 descriptor bytes.
- R5: Each accepted launch receives an identifier one greater than the one before it, starting at 0. A refused launch consumes no identifier.
- R6: A slot holds, for each dimension, the ceiling of the grid extent divided by the workgroup extent, and it holds the product of the three counts. A workgroup extent of zero yields a count of zero.
- R7: From the cycle a launch is accepted until its response, `reqReady` is low for at least as many cycles as the extent width. No response is issued while `reqReady` is low.
- R8: The pending queue returns launches in launch order. `pendPop` removes the head, and the queue reports empty once all entries are popped.
- R9: When all eight slots are in use, a launch is refused: it gets an error response, raises the error flag and pushes nothing. A later launch takes the lowest-numbered free slot.
- R10: The active flag is set once any launch is accepted and clears only when every slot has been retired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Bus request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | ADDR_W | Byte offset of the access |
| reqSize | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| reqWdata | input | 64 | Write data, little-endian from bit 0 |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Response is an error |
| rspRdata | output | 64 | Read data, valid with rspValid |
| pendValid | output | 1 | Pending queue is not empty |
| pendPop | input | 1 | Remove the queue head |
| pendId | output | ID_W | Kernel identifier of the head |
| pendSlot | output | SLOT_W | Slot index of the head |
| pendWg | output | 3*DIM_W | Workgroup counts of the head, dimension d at bits d*DIM_W |
| pendTotal | output | 3*DIM_W | Product of the head's three counts |
| retireValid | input | 1 | Free the slot named by retireSlot |
| retireSlot | input | SLOT_W | Slot to free |

## Verification
The hardest case to reach is a launch refused because the slot table is full. It needs eight accepted launches with no retirement in between, each stalling the bus for a full division. After the refusal the bench shows that nothing was queued by draining the queue and counting its entries. It then shows that allocation restarts at the lowest free index by retiring two slots out of order before the next launch. A zero workgroup extent and a grid extent that is not a multiple of the workgroup extent are staged between launches to exercise both ends of the ceiling division.

// File: rtl/klr_pkg.sv
package klr_pkg;
  localparam int WINDOW_BYTES = 4096;
  localparam int STATUS_BYTES = 8;

  typedef struct packed {
    logic stageWr;   // write staged descriptor bytes
    logic launchGo;  // start dividers, capture free slot
    logic commit;    // fill slot, push queue, bump id
    logic refuse;    // launch with table full
    logic rdStatus;  // load status word, clear error flag
    logic rdDesc;    // load descriptor bytes
  } ctrlStb_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DIVIDE = 2'd1,
    ST_COMMIT = 2'd2
  } ctrlState_t;
endpackage

// File: rtl/klr_ceil_div.sv
module klr_ceil_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int CNT_W = $clog2(W + 1);

  logic         busy;
  logic         zeroDiv;
  logic [CNT_W-1:0] stepsLeft;
  logic [W-1:0] quot;
  logic [W-1:0] remReg;
  logic [W-1:0] divReg;
  logic [W:0]   trial;
  logic         fits;
  logic [W-1:0] remNext;

  always_comb begin
    trial   = {remReg, quot[W-1]};
    fits    = trial >= {1'b0, divReg};
    remNext = fits ? W'(trial - {1'b0, divReg}) : trial[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      zeroDiv   <= 1'b0;
      stepsLeft <= '0;
      quot      <= '0;
      remReg    <= '0;
      divReg    <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      done      <= 1'b0;
      zeroDiv   <= (divisor == '0);
      stepsLeft <= CNT_W'(W);
      quot      <= dividend;
      remReg    <= '0;
      divReg    <= divisor;
    end else if (busy) begin
      remReg    <= remNext;
      quot      <= {quot[W-2:0], fits};
      stepsLeft <= stepsLeft - 1'b1;
      if (stepsLeft == CNT_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assign result = zeroDiv ? '0 : quot + W'(remReg != '0);
endmodule

// File: rtl/klr_ctrl.sv
module klr_ctrl
  import klr_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DESC_BYTES = 24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              slotFree,
  input  logic              divDone,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspErr,
  output ctrlStb_t          stb
);
  ctrlState_t state, stateNext;
  logic rspValidNext, rspErrNext;

  logic [31:0] addr32, nBytes;
  logic inWindow, aligned, atLaunch, descOk, legal, accept;

  always_comb begin
    addr32   = 32'(reqAddr);
    nBytes   = 32'd1 << reqSize;
    inWindow = addr32 < 32'(WINDOW_BYTES);
    aligned  = (addr32 & (nBytes - 32'd1)) == 32'd0;
    atLaunch = addr32 == 32'd0;
    descOk   = (addr32 >= 32'(STATUS_BYTES)) &&
               (addr32 + nBytes <= 32'(STATUS_BYTES + DESC_BYTES));
    legal    = inWindow && aligned &&
               ((atLaunch && (reqWrite || reqSize == 2'd3)) || descOk);
  end

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    stb          = '0;
    stateNext    = state;
    rspValidNext = 1'b0;
    rspErrNext   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (accept) begin
          rspValidNext = 1'b1;
          if (!legal) begin
            rspErrNext = 1'b1;
          end else if (atLaunch && reqWrite) begin
            if (slotFree) begin
              stb.launchGo = 1'b1;
              rspValidNext = 1'b0;
              stateNext    = ST_DIVIDE;
            end else begin
              stb.refuse = 1'b1;
              rspErrNext = 1'b1;
            end
          end else if (reqWrite) begin
            stb.stageWr = 1'b1;
          end else if (atLaunch) begin
            stb.rdStatus = 1'b1;
          end else begin
            stb.rdDesc = 1'b1;
          end
        end
      end
      ST_DIVIDE: begin
        if (divDone) stateNext = ST_COMMIT;
      end
      ST_COMMIT: begin
        stb.commit   = 1'b1;
        rspValidNext = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      state    <= stateNext;
      rspValid <= rspValidNext;
      rspErr   <= rspErrNext;
    end
  end
endmodule

// File: rtl/klr_datapath.sv
module klr_datapath
  import klr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 32,
  parameter int SLOTS  = 8,
  parameter int ID_W   = 8,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int DESC_BYTES = 6 * DIM_W / 8,
  localparam int DESC_W     = DESC_BYTES * 8,
  localparam int WG_W       = 3 * DIM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  input  logic              pendPop,
  input  logic              retireValid,
  input  logic [SLOT_W-1:0] retireSlot,
  output logic [63:0]       rspRdata,
  output logic              pendValid,
  output logic [ID_W-1:0]   pendId,
  output logic [SLOT_W-1:0] pendSlot,
  output logic [WG_W-1:0]   pendWg,
  output logic [WG_W-1:0]   pendTotal,
  output logic              slotFree,
  output logic              divDone,
  output logic [ID_W-1:0]   curId,
  output logic              errFlag,
  output logic [SLOT_W:0]   qCount
);
  // descriptor staging
  logic [DESC_W-1:0] descReg;
  logic [31:0]       descIdx, nBytes;
  logic [DESC_W-1:0] descShift;
  logic [63:0]       sizeMask;

  assign descIdx = 32'(reqAddr) - 32'(STATUS_BYTES);
  assign nBytes  = 32'd1 << reqSize;

  always_comb begin
    unique case (reqSize)
      2'd0:    sizeMask = 64'h0000_0000_0000_00FF;
      2'd1:    sizeMask = 64'h0000_0000_0000_FFFF;
      2'd2:    sizeMask = 64'h0000_0000_FFFF_FFFF;
      default: sizeMask = '1;
    endcase
    descShift = descReg >> {descIdx, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descReg <= '0;
    end else if (stb.stageWr) begin
      for (int j = 0; j < DESC_BYTES; j++) begin
        logic [31:0] lane;
        lane = 32'(j) - descIdx;
        if (32'(j) >= descIdx && lane < nBytes)
          descReg[j*8 +: 8] <= reqWdata[lane[2:0]*8 +: 8];
      end
    end
  end

  // workgroup count dividers, one per dimension
  logic [2:0]      doneVec;
  logic [WG_W-1:0] wgCnt;

  for (genvar d = 0; d < 3; d++) begin : g_div
    klr_ceil_div #(.W(DIM_W)) u_div (
      .clk      (clk),
      .rstN     (rstN),
      .start    (stb.launchGo),
      .dividend (descReg[d*DIM_W +: DIM_W]),
      .divisor  (descReg[(d+3)*DIM_W +: DIM_W]),
      .done     (doneVec[d]),
      .result   (wgCnt[d*DIM_W +: DIM_W])
    );
  end

  assign divDone = &doneVec;

  logic [WG_W-1:0] wgTotal;
  assign wgTotal = WG_W'(wgCnt[0 +: DIM_W]) *
                   WG_W'(wgCnt[DIM_W +: DIM_W]) *
                   WG_W'(wgCnt[2*DIM_W +: DIM_W]);

  // slot table
  logic [SLOTS-1:0]  slotValid;
  logic [ID_W-1:0]   slotId    [SLOTS];
  logic [WG_W-1:0]   slotWg    [SLOTS];
  logic [WG_W-1:0]   slotTotal [SLOTS];
  logic [SLOT_W-1:0] freeIdx, pickSlot;

  always_comb begin
    slotFree = 1'b0;
    freeIdx  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!slotValid[s]) begin
        slotFree = 1'b1;
        freeIdx  = SLOT_W'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
      pickSlot  <= '0;
      curId     <= '0;
    end else begin
      if (stb.launchGo) pickSlot <= freeIdx;
      if (retireValid)  slotValid[retireSlot] <= 1'b0;
      if (stb.commit) begin
        slotValid[pickSlot] <= 1'b1;
        curId               <= curId + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit) begin
      slotId[pickSlot]    <= curId;
      slotWg[pickSlot]    <= wgCnt;
      slotTotal[pickSlot] <= wgTotal;
    end
  end

  // pending queue of slot indices
  logic [SLOT_W-1:0] qMem [SLOTS];
  logic [SLOT_W-1:0] rdPtr, wrPtr;
  logic              doPop;

  assign pendValid = (qCount != '0);
  assign doPop     = pendPop && pendValid;

  function automatic logic [SLOT_W-1:0] bump(input logic [SLOT_W-1:0] p);
    return (p == SLOT_W'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr  <= '0;
      wrPtr  <= '0;
      qCount <= '0;
    end else begin
      if (stb.commit) wrPtr <= bump(wrPtr);
      if (doPop)      rdPtr <= bump(rdPtr);
      qCount <= qCount + (SLOT_W+1)'(stb.commit) - (SLOT_W+1)'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.commit) qMem[wrPtr] <= pickSlot;
  end

  assign pendSlot  = qMem[rdPtr];
  assign pendId    = slotId[pendSlot];
  assign pendWg    = slotWg[pendSlot];
  assign pendTotal = slotTotal[pendSlot];

  // error flag and read data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag  <= 1'b0;
      rspRdata <= '0;
    end else begin
      if (stb.refuse)        errFlag <= 1'b1;
      else if (stb.rdStatus) errFlag <= 1'b0;
      if (stb.rdStatus)
        rspRdata <= {62'd0, errFlag, |slotValid};
      else if (stb.rdDesc)
        rspRdata <= 64'(descShift) & sizeMask;
      else
        rspRdata <= '0;
    end
  end
endmodule

// File: rtl/kernel_launch_regs.sv
module kernel_launch_regs
  import klr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 32,
  parameter int SLOTS  = 8,
  parameter int ID_W   = 8,
  localparam int SLOT_W     = $clog2(SLOTS),
  localparam int DESC_BYTES = 6 * DIM_W / 8,
  localparam int WG_W       = 3 * DIM_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic              rspErr,
  output logic [63:0]       rspRdata,
  output logic              pendValid,
  input  logic              pendPop,
  output logic [ID_W-1:0]   pendId,
  output logic [SLOT_W-1:0] pendSlot,
  output logic [WG_W-1:0]   pendWg,
  output logic [WG_W-1:0]   pendTotal,
  input  logic              retireValid,
  input  logic [SLOT_W-1:0] retireSlot
);
  ctrlStb_t          stb;
  logic              slotFree, divDone, errFlag;
  logic [ID_W-1:0]   curId;
  logic [SLOT_W:0]   qCount;

  klr_ctrl #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .slotFree (slotFree),
    .divDone  (divDone),
    .reqReady (reqReady),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .stb      (stb)
  );

  klr_datapath #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .SLOTS(SLOTS), .ID_W(ID_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .reqAddr     (reqAddr),
    .reqSize     (reqSize),
    .reqWdata    (reqWdata),
    .pendPop     (pendPop),
    .retireValid (retireValid),
    .retireSlot  (retireSlot),
    .rspRdata    (rspRdata),
    .pendValid   (pendValid),
    .pendId      (pendId),
    .pendSlot    (pendSlot),
    .pendWg      (pendWg),
    .pendTotal   (pendTotal),
    .slotFree    (slotFree),
    .divDone     (divDone),
    .curId       (curId),
    .errFlag     (errFlag),
    .qCount      (qCount)
  );
endmodule

// File: rtl/klr_checker.sv
module klr_checker #(
  parameter int ADDR_W = 16,
  parameter int SLOTS  = 8,
  parameter int ID_W   = 8,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic              rspErr,
  input logic              commit,
  input logic              errClr,
  input logic              errFlag,
  input logic [ID_W-1:0]   curId,
  input logic [SLOT_W:0]   qCount
);
  // R4: out-of-window access answered with an error on the next cycle
  p_oob_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && 32'(reqAddr) >= 32'd4096) |=> (rspValid && rspErr));

  // R5: each committed launch advances the identifier by one
  p_id_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> (curId == ID_W'($past(curId) + 1'b1)));

  // R7: no response while the bus is stalled
  p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !reqReady |-> !rspValid);

  // R8: queue occupancy never exceeds the slot count
  p_queue_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    qCount <= (SLOT_W+1)'(SLOTS));

  // R9: the error flag holds until a status read clears it
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);
endmodule

bind kernel_launch_regs klr_checker #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .ID_W(ID_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .reqAddr  (reqAddr),
  .rspValid (rspValid),
  .rspErr   (rspErr),
  .commit   (stb.commit),
  .errClr   (stb.rdStatus),
  .errFlag  (errFlag),
  .curId    (curId),
  .qCount   (qCount)
);

// File: tb/test_kernel_launch_regs.sv
`timescale 1ns/1ps
module test_kernel_launch_regs;
  localparam int ADDR_W = 16;
  localparam int DIM_W  = 32;
  localparam int SLOTS  = 8;
  localparam int ID_W   = 8;
  localparam int SLOT_W = 3;
  localparam int WG_W   = 3 * DIM_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0, reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic [63:0]       reqWdata = '0;
  logic              reqReady, rspValid, rspErr, pendValid;
  logic [63:0]       rspRdata;
  logic              pendPop = 1'b0, retireValid = 1'b0;
  logic [SLOT_W-1:0] retireSlot = '0;
  logic [ID_W-1:0]   pendId;
  logic [SLOT_W-1:0] pendSlot;
  logic [WG_W-1:0]   pendWg, pendTotal;

  always #10 clk = ~clk;

  kernel_launch_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .SLOTS(SLOTS), .ID_W(ID_W))
    i_kernel_launch_regs (.*);

  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  task automatic chkEq(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busOp(input logic wr, input logic [ADDR_W-1:0] addr, input logic [1:0] sz,
                       input logic [63:0] wd, output logic err, output logic [63:0] rd,
                       output int stall);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = sz; reqWdata = wd;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    stall = 0;
    while (!rspValid) begin
      if (!reqReady) stall++;
      @(negedge clk);
    end
    err = rspErr;
    rd  = rspRdata;
  endtask

  task automatic popHead();
    @(negedge clk); pendPop = 1'b1;
    @(negedge clk); pendPop = 1'b0;
  endtask

  task automatic retire(input int s);
    @(negedge clk); retireValid = 1'b1; retireSlot = SLOT_W'(s);
    @(negedge clk); retireValid = 1'b0;
  endtask

  typedef struct packed {
    logic [23:0]       tag;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        size;
    logic [63:0]       wdata;
    logic              expErr;
    logic [63:0]       expData;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{"R1", 1'b0, 16'd0,    2'd3, 64'd0,   1'b0, 64'd0},
    '{"R3", 1'b1, 16'd8,    2'd2, 64'd100, 1'b0, 64'd0},
    '{"R3", 1'b1, 16'd12,   2'd2, 64'd33,  1'b0, 64'd0},
    '{"R3", 1'b1, 16'd16,   2'd2, 64'd7,   1'b0, 64'd0},
    '{"R3", 1'b1, 16'd20,   2'd2, 64'd10,  1'b0, 64'd0},
    '{"R3", 1'b1, 16'd24,   2'd3, 64'h0000_0004_0000_0008, 1'b0, 64'd0},
    '{"R3", 1'b0, 16'd8,    2'd3, 64'd0,   1'b0, 64'h0000_0021_0000_0064},
    '{"R3", 1'b0, 16'd24,   2'd3, 64'd0,   1'b0, 64'h0000_0004_0000_0008},
    '{"R3", 1'b1, 16'd10,   2'd1, 64'd0,   1'b0, 64'd0},
    '{"R3", 1'b0, 16'd8,    2'd1, 64'd0,   1'b0, 64'h64},
    '{"R3", 1'b0, 16'd9,    2'd0, 64'd0,   1'b0, 64'h0},
    '{"R4", 1'b0, 16'd0,    2'd2, 64'd0,   1'b1, 64'd0},
    '{"R4", 1'b1, 16'd12,   2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'd0},
    '{"R4", 1'b0, 16'd32,   2'd0, 64'd0,   1'b1, 64'd0},
    '{"R4", 1'b0, 16'd4096, 2'd2, 64'd0,   1'b1, 64'd0},
    '{"R4", 1'b1, 16'd4,    2'd2, 64'd5,   1'b1, 64'd0},
    '{"R4", 1'b0, 16'd8,    2'd2, 64'd0,   1'b0, 64'd100},
    '{"R4", 1'b0, 16'd12,   2'd2, 64'd0,   1'b0, 64'd33}
  };

  initial begin : main
    logic err;
    logic [63:0] rd;
    int stall;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chkEq("R1 rspValid after reset", rspValid, 0);
    chkEq("R1 pendValid after reset", pendValid, 0);
    chkEq("R1 reqReady after reset", reqReady, 1);

    for (int i = 0; i < NV; i++) begin
      busOp(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata, err, rd, stall);
      chkEq($sformatf("%s vector %0d err", VECS[i].tag, i), err, VECS[i].expErr);
      if (!VECS[i].wr)
        chkEq($sformatf("%s vector %0d data", VECS[i].tag, i), rd, VECS[i].expData);
    end

    // first launch: counts 10,5,2 total 100
    busOp(1'b1, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R5 launch0 err", err, 0);
    chkEq("R7 launch0 stall", 128'(stall >= DIM_W), 1);
    chkEq("R5 head id 0", pendId, 0);
    chkEq("R9 head slot 0", pendSlot, 0);
    chkEq("R6 head counts", pendWg, {32'd2, 32'd5, 32'd10});
    chkEq("R6 head total", pendTotal, 100);
    busOp(1'b0, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R10 active after launch", rd, 64'd1);

    // second launch with zero workgroup x extent
    busOp(1'b1, 16'd20, 2'd2, 64'd0, err, rd, stall);
    busOp(1'b1, 16'd0, 2'd0, 64'd0, err, rd, stall);
    chkEq("R5 launch1 err", err, 0);
    chkEq("R8 head still id 0", pendId, 0);
    popHead();
    chkEq("R8 head id 1", pendId, 1);
    chkEq("R6 zero extent counts", pendWg, {32'd2, 32'd5, 32'd0});
    chkEq("R6 zero extent total", pendTotal, 0);
    popHead();
    chkEq("R8 queue empty", pendValid, 0);

    // six more launches fill the table, grid x 101 -> 11
    busOp(1'b1, 16'd20, 2'd2, 64'd10, err, rd, stall);
    busOp(1'b1, 16'd8, 2'd2, 64'd101, err, rd, stall);
    for (int k = 0; k < 6; k++) begin
      busOp(1'b1, 16'd0, 2'd3, 64'd0, err, rd, stall);
      chkEq($sformatf("R5 launch %0d err", k + 2), err, 0);
    end
    busOp(1'b1, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R9 refused launch err", err, 1);
    busOp(1'b0, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R2 status active and error", rd, 64'd3);
    busOp(1'b0, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R2 error cleared by read", rd, 64'd1);

    for (int k = 0; k < 6; k++) begin
      chkEq($sformatf("R8 order id %0d", k + 2), pendId, 128'(k + 2));
      chkEq($sformatf("R6 count x id %0d", k + 2), pendWg[DIM_W-1:0], 11);
      popHead();
    end
    chkEq("R9 refused launch not queued", pendValid, 0);

    retire(5);
    retire(3);
    busOp(1'b1, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R9 relaunch err", err, 0);
    chkEq("R9 lowest free slot", pendSlot, 3);
    chkEq("R5 id skips refused launch", pendId, 8);
    chkEq("R6 relaunch total", pendTotal, 110);
    popHead();

    for (int s = 0; s < SLOTS; s++) retire(s);
    busOp(1'b0, 16'd0, 2'd3, 64'd0, err, rd, stall);
    chkEq("R10 inactive after retire all", rd, 64'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule